// File: doc/BRIEF.md
# Calendar Real-Time Clock with Field-Masked Alarm

This peripheral keeps wall-clock time in hardware. It divides an incoming tick pulse down to one pulse per second. That pulse drives a cascade of eight counters: second, minute, hour, day of month, day of week, day of year, month and year. Month lengths and leap years are handled in hardware. Software reaches every counter through a plain 32-bit register bus. It can read or write each field in its own word. It can also read the whole time as three packed words.

An alarm comparator checks the counters against eight alarm fields. A mask register leaves any subset of fields out of the compare. A separate enable register chooses which counter increments raise an event. Both kinds of event are latched in a status register and combined onto a single interrupt line. The bus has no handshake: a write is accepted in the cycle `bus_wr` is high, and read data follows `bus_addr` combinationally, so there is no back-pressure.

To set the time safely, software writes the seconds counter to 0 first. It then writes the other fields and writes the real seconds value last. Each seconds write restarts the sub-second divider, so no carry reaches the upper fields during the update.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the counters read second 0, minute 0, hour 0, day of week 0, year 0, and day of month, day of year and month 1. Control (0x08) reads 0, increment enables (0x0C) read 0, the alarm mask (0x10) reads 0xFF, status (0x00) reads 0 and `irq` is low.
- R2: Control bit 0 enables counting and control bit 1 holds the divider at zero. A second elapses on every PRESCALE-th `tick` only while bit 0 is 1 and bit 1 is 0. Otherwise all counters hold. Bit 4 is storage only.
- R3: Second and minute wrap from 59 to 0, and hour wraps from 23 to 0. Each wrap carries one step into the next field.
- R4: On an hour wrap, day of week advances and wraps from 6 to 0. Day of year advances and wraps to 1 after 365, or after 366 when year mod 4 is 0. Day of month advances and wraps to 1 past the month length (30 for months 4, 6, 9 and 11; 29 or 28 for month 2; 31 otherwise), and that wrap advances month. Month wraps from 12 to 1 and that wrap advances year.
- R5: Snapshot 0x14 holds second in [5:0], minute in [13:8], hour in [20:16] and day of week in [26:24]. Snapshot 0x18 holds day of month in [4:0], month in [11:8] and year in [27:16]. Snapshot 0x1C holds day of year in [11:0]. All other bits read 0.
- R6: Field index k is 0 for second, 1 for minute, 2 for hour, 3 for day of month, 4 for day of week, 5 for day of year, 6 for month and 7 for year. The counter for index k is at 0x20+4k and the alarm value for index k is at 0x60+4k. A write takes effect at the next clock edge and overrides counting for that field.
- R7: A write to the seconds counter (0x20) restarts the divider, so the next second elapses a full PRESCALE ticks later.
- R8: Alarm mask bit k set drops field k from the compare. The alarm flag (status bit 1) sets one clock after a second elapses that leaves every unmasked field equal to its alarm value. A mask of 0xFF never sets it.
- R9: Increment-enable bit k (same index order) sets the increment flag (status bit 0) in the cycle field k is stepped by counting.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. `irq` is high exactly while any status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sub-second tick pulse, one per divider step |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt, OR of the status flags |

## Verification
The bench builds the block with PRESCALE set to 4, so one second takes four enabled clocks. With that setting the exact edge of every second can be counted, and the restart of the divider on a seconds write can be seen. Time is preloaded to just before each boundary: minute, midnight, month ends with and without a leap year, and year ends of 365 and 366 days. One second then reaches every carry path, every masked alarm compare and every increment event in a few clocks.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DOM_W  = 5;
  localparam int DOW_W  = 3;
  localparam int DOY_W  = 9;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 12;
  localparam int NFIELD = 8;
  localparam int FIELD_W = 12;
  localparam int IDX_W  = $clog2(NFIELD);

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  mon;
    logic [DOY_W-1:0]  doy;
    logic [DOW_W-1:0]  dow;
    logic [DOM_W-1:0]  dom;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } cal_t;

  function automatic logic [DOM_W-1:0] month_len(logic [MON_W-1:0] m, logic leap);
    case (m)
      4'd2:                   return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                return 5'd31;
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] field_get(cal_t t, logic [IDX_W-1:0] k);
    case (k)
      3'd0:    return FIELD_W'(t.sec);
      3'd1:    return FIELD_W'(t.min);
      3'd2:    return FIELD_W'(t.hour);
      3'd3:    return FIELD_W'(t.dom);
      3'd4:    return FIELD_W'(t.dow);
      3'd5:    return FIELD_W'(t.doy);
      3'd6:    return FIELD_W'(t.mon);
      default: return t.year;
    endcase
  endfunction

  function automatic cal_t field_set(cal_t t, logic [IDX_W-1:0] k, logic [FIELD_W-1:0] v);
    cal_t r;
    r = t;
    case (k)
      3'd0:    r.sec  = v[SEC_W-1:0];
      3'd1:    r.min  = v[MIN_W-1:0];
      3'd2:    r.hour = v[HOUR_W-1:0];
      3'd3:    r.dom  = v[DOM_W-1:0];
      3'd4:    r.dow  = v[DOW_W-1:0];
      3'd5:    r.doy  = v[DOY_W-1:0];
      3'd6:    r.mon  = v[MON_W-1:0];
      default: r.year = v;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic clr,
  output logic sec_tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign sec_tick = run && tick && !clr && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr)        cnt_q <= '0;
    else if (run && tick) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [FIELD_W-1:0] wr_val,
  output cal_t               now,
  output logic [NFIELD-1:0]  stepped
);
  cal_t cur_q, nxt;
  logic leap;
  logic [DOY_W-1:0] ylen;
  logic [DOM_W-1:0] mlen;

  assign leap = (cur_q.year[1:0] == 2'b00);
  assign ylen = leap ? 9'd366 : 9'd365;
  assign mlen = month_len(cur_q.mon, leap);

  always_comb begin
    nxt = cur_q;
    stepped = '0;
    if (sec_tick) begin
      stepped[0] = 1'b1;
      if (cur_q.sec >= 6'd59) begin
        nxt.sec = '0;
        stepped[1] = 1'b1;
        if (cur_q.min >= 6'd59) begin
          nxt.min = '0;
          stepped[2] = 1'b1;
          if (cur_q.hour >= 5'd23) begin
            nxt.hour = '0;
            stepped[3] = 1'b1;
            stepped[4] = 1'b1;
            stepped[5] = 1'b1;
            nxt.dow = (cur_q.dow >= 3'd6) ? '0 : cur_q.dow + 3'd1;
            nxt.doy = (cur_q.doy >= ylen) ? 9'd1 : cur_q.doy + 9'd1;
            if (cur_q.dom >= mlen) begin
              nxt.dom = 5'd1;
              stepped[6] = 1'b1;
              if (cur_q.mon >= 4'd12) begin
                nxt.mon = 4'd1;
                stepped[7] = 1'b1;
                nxt.year = cur_q.year + 12'd1;
              end else begin
                nxt.mon = cur_q.mon + 4'd1;
              end
            end else begin
              nxt.dom = cur_q.dom + 5'd1;
            end
          end else begin
            nxt.hour = cur_q.hour + 5'd1;
          end
        end else begin
          nxt.min = cur_q.min + 6'd1;
        end
      end else begin
        nxt.sec = cur_q.sec + 6'd1;
      end
    end
    if (wr_en) nxt = field_set(nxt, wr_idx, wr_val);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q      <= '0;
      cur_q.dom  <= 5'd1;
      cur_q.doy  <= 9'd1;
      cur_q.mon  <= 4'd1;
    end else begin
      cur_q <= nxt;
    end
  end

  assign now = cur_q;

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_en && cur_q.sec == 6'd59) |=> (cur_q.sec == '0));
  p_year_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_en && cur_q.sec == 6'd59 && cur_q.min == 6'd59 &&
     cur_q.hour == 5'd23 && cur_q.mon == 4'd12 && cur_q.dom == 5'd31)
    |=> (cur_q.mon == 4'd1 && cur_q.dom == 5'd1 && cur_q.doy == 9'd1));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !wr_en) |=> $stable(cur_q));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_cal_pkg::*;
(
  input  cal_t              now,
  input  cal_t              target,
  input  logic [NFIELD-1:0] mask,
  output logic              hit
);
  logic [NFIELD-1:0] eq;

  for (genvar k = 0; k < NFIELD; k++) begin : g_cmp
    assign eq[k] = (field_get(now, IDX_W'(k)) == field_get(target, IDX_W'(k)));
  end

  assign hit = (mask != '1) && (&(eq | mask));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam logic [7:0] A_STAT  = 8'h00;
  localparam logic [7:0] A_CTRL  = 8'h08;
  localparam logic [7:0] A_INCEN = 8'h0C;
  localparam logic [7:0] A_AMASK = 8'h10;
  localparam logic [7:0] A_SNAP0 = 8'h14;
  localparam logic [7:0] A_SNAP1 = 8'h18;
  localparam logic [7:0] A_SNAP2 = 8'h1C;
  localparam logic [2:0] BLK_CNT = 3'b001;
  localparam logic [2:0] BLK_ALM = 3'b011;
  localparam logic [4:0] CTRL_KEEP = 5'b10011;

  logic [4:0]        ctrl_q;
  logic [NFIELD-1:0] incen_q, amask_q;
  logic [1:0]        status_q, status_n;
  cal_t              alm_q, now;
  logic              tick_d, sec_tick, hit, run, clr;
  logic [NFIELD-1:0] stepped;
  logic              wr_cnt, wr_alm, wr_stat, wr_sec;
  logic [IDX_W-1:0]  idx;
  logic              unused_bits;

  assign idx     = bus_addr[4:2];
  assign wr_cnt  = bus_wr && (bus_addr[7:5] == BLK_CNT);
  assign wr_alm  = bus_wr && (bus_addr[7:5] == BLK_ALM);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_sec  = wr_cnt && (idx == '0);
  assign run     = ctrl_q[0] && !ctrl_q[1];
  assign clr     = ctrl_q[1] || wr_sec;
  assign unused_bits = ^{bus_wdata[31:12], bus_addr[1:0]};

  rtc_prescaler #(.DIV(PRESCALE)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .clr(clr), .sec_tick(sec_tick)
  );

  rtc_time_core u_core (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_cnt), .wr_idx(idx),
    .wr_val(bus_wdata[FIELD_W-1:0]), .now(now), .stepped(stepped)
  );

  rtc_alarm_match u_alarm (
    .now(now), .target(alm_q), .mask(amask_q), .hit(hit)
  );

  always_comb begin
    status_n = status_q & ~(wr_stat ? bus_wdata[1:0] : 2'b00);
    if (|(stepped & incen_q)) status_n[0] = 1'b1;
    if (tick_d && hit)        status_n[1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      incen_q  <= '0;
      amask_q  <= '1;
      status_q <= '0;
      alm_q    <= '0;
      tick_d   <= 1'b0;
    end else begin
      tick_d   <= sec_tick;
      status_q <= status_n;
      if (bus_wr && bus_addr == A_CTRL)  ctrl_q  <= bus_wdata[4:0] & CTRL_KEEP;
      if (bus_wr && bus_addr == A_INCEN) incen_q <= bus_wdata[NFIELD-1:0];
      if (bus_wr && bus_addr == A_AMASK) amask_q <= bus_wdata[NFIELD-1:0];
      if (wr_alm) alm_q <= field_set(alm_q, idx, bus_wdata[FIELD_W-1:0]);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[7:5] == BLK_CNT)      bus_rdata = 32'(field_get(now, idx));
    else if (bus_addr[7:5] == BLK_ALM) bus_rdata = 32'(field_get(alm_q, idx));
    else begin
      case (bus_addr)
        A_STAT:  bus_rdata = 32'(status_q);
        A_CTRL:  bus_rdata = 32'(ctrl_q);
        A_INCEN: bus_rdata = 32'(incen_q);
        A_AMASK: bus_rdata = 32'(amask_q);
        A_SNAP0: bus_rdata = {5'b0, now.dow, 3'b0, now.hour, 2'b0, now.min, 2'b0, now.sec};
        A_SNAP1: bus_rdata = {4'b0, now.year, 4'b0, now.mon, 3'b0, now.dom};
        A_SNAP2: bus_rdata = {20'b0, 3'b0, now.doy};
        default: bus_rdata = {31'b0, unused_bits & 1'b0};
      endcase
    end
  end

  assign irq = |status_q;

  p_alarm_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (amask_q == '1 && !status_q[1]) |=> !status_q[1]);
  p_incr_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (incen_q == '0 && !status_q[0]) |=> !status_q[0]);
  p_alarm_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[1] && !(wr_stat && bus_wdata[1])) |=> status_q[1]);
endmodule

// File: tb/rtc_calendar_test.sv
`timescale 1ns/1ps
module rtc_calendar_test;
  localparam int PS = 4;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_calendar #(.PRESCALE(PS)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // field order: sec, min, hour, dom, dow, doy, mon, year; start then expected
  localparam int NV = 8;
  localparam logic [11:0] TV [NV][16] = '{
    '{10,30,12, 5,2, 64, 3,2023,  11,30,12, 5,2, 64, 3,2023},
    '{59,30,12, 5,2, 64, 3,2023,   0,31,12, 5,2, 64, 3,2023},
    '{59,59,23,28,6, 59, 2,2023,   0, 0, 0, 1,0, 60, 3,2023},
    '{59,59,23,28,3, 59, 2,2024,   0, 0, 0,29,4, 60, 2,2024},
    '{59,59,23,31,0,365,12,2023,   0, 0, 0, 1,1,  1, 1,2024},
    '{59,59,23,30,5,120, 4,2023,   0, 0, 0, 1,6,121, 5,2023},
    '{59,59,23,31,2,366,12,2024,   0, 0, 0, 1,3,  1, 1,2025},
    '{59,59,23,29,1, 60, 2,2024,   0, 0, 0, 1,2, 61, 3,2024}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic run_secs(input int n);
    wr(8'h08, 32'h1);
    repeat (4*n - 2) @(negedge clk);
    wr(8'h08, 32'h0);
  endtask

  function automatic logic [31:0] pack0(input logic [11:0] f[16], input int o);
    return {5'b0, f[o+4][2:0], 3'b0, f[o+2][4:0], 2'b0, f[o+1][5:0], 2'b0, f[o][5:0]};
  endfunction
  function automatic logic [31:0] pack1(input logic [11:0] f[16], input int o);
    return {4'b0, f[o+7], 4'b0, f[o+6][3:0], 3'b0, f[o+3][4:0]};
  endfunction

  task automatic set_time(input logic [11:0] f[16]);
    wr(8'h20, 32'h0);
    for (int k = 7; k >= 1; k--) wr(8'(8'h20 + 4*k), 32'(f[k]));
    wr(8'h20, 32'(f[0]));
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [11:0] f [16];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h08, d); chk("R1 ctrl", d, 0);
    rd(8'h10, d); chk("R1 amask", d, 32'hFF);
    rd(8'h0C, d); chk("R1 incen", d, 0);
    rd(8'h20, d); chk("R1 sec", d, 0);
    rd(8'h18, d); chk("R1 snap1", d, 32'h0000_0101);
    rd(8'h1C, d); chk("R1 snap2", d, 1);
    rd(8'h00, d); chk("R1 status", d, 0);
    chk("R1 irq", 32'(irq), 0);

    // R3 R4 R5 R6 vector table: one second from each preset
    for (int v = 0; v < NV; v++) begin
      f = TV[v];
      set_time(f);
      run_secs(1);
      rd(8'h14, d); chk($sformatf("R3 R5 snap0 v%0d", v), d, pack0(f, 8));
      rd(8'h18, d); chk($sformatf("R4 R5 snap1 v%0d", v), d, pack1(f, 8));
      rd(8'h1C, d); chk($sformatf("R4 R5 snap2 v%0d", v), d, 32'(f[13]));
      rd(8'h24, d); chk($sformatf("R6 min reg v%0d", v), d, 32'(f[9]));
    end
    rd(8'h00, d); chk("R8 mask FF never alarms", d, 0);

    // R2 hold while disabled, and while divider reset
    wr(8'h20, 32'd7);
    repeat (20) @(negedge clk);
    rd(8'h20, d); chk("R2 disabled hold", d, 7);
    wr(8'h08, 32'h13);
    repeat (20) @(negedge clk);
    rd(8'h20, d); chk("R2 divider reset hold", d, 7);
    rd(8'h08, d); chk("R2 ctrl bits", d, 32'h13);
    wr(8'h08, 32'h0);

    // R7 seconds write restarts divider
    wr(8'h20, 32'd5);
    wr(8'h08, 32'h1);
    wr(8'h20, 32'd5);
    repeat (2) @(negedge clk);
    rd(8'h20, d); chk("R7 no early second", d, 5);
    rd(8'h20, d); chk("R7 second after full period", d, 6);
    wr(8'h08, 32'h0);

    // R8 alarm: hour compared and mismatched -> no flag
    wr(8'h00, 32'h3);
    wr(8'h28, 32'd7); wr(8'h24, 32'd5);
    wr(8'h60, 32'd30); wr(8'h64, 32'd5); wr(8'h68, 32'd9);
    wr(8'h10, 32'hF8);
    wr(8'h20, 32'd29);
    run_secs(1);
    rd(8'h00, d); chk("R8 unmasked mismatch", d, 0);
    // hour masked -> flag one clock after the matching second
    wr(8'h10, 32'hFC);
    wr(8'h20, 32'd29);
    run_secs(1);
    rd(8'h00, d); chk("R8 masked match sets alarm", d, 2);
    chk("R10 irq follows status", 32'(irq), 1);
    wr(8'h00, 32'h1);
    rd(8'h00, d); chk("R10 write 0 keeps flag", d, 2);
    wr(8'h00, 32'h2);
    rd(8'h00, d); chk("R10 W1C clears alarm", d, 0);
    chk("R10 irq low", 32'(irq), 0);
    wr(8'h10, 32'hFF);

    // R9 increment enable on minute step only
    wr(8'h0C, 32'h02);
    wr(8'h20, 32'd58);
    run_secs(1);
    rd(8'h00, d); chk("R9 sec step not enabled", d, 0);
    run_secs(1);
    rd(8'h00, d); chk("R9 minute step flags", d, 1);
    chk("R9 irq", 32'(irq), 1);
    wr(8'h00, 32'h1);
    rd(8'h00, d); chk("R10 W1C incr", d, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule